// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits between the command decoder and the column path of a two-bank synchronous graphics DRAM. A mode-set command loads a small mode register from the address bus. That register holds the burst length, the beat ordering, the read latency and a single-beat-write option. Every read or write command then starts a burst.

For each beat of a burst the block drives the column address and the bank on the cycle after the command edge, and on each following cycle. It raises a done flag on the last beat. It also produces a read-data-valid strobe that lags each read beat, so that the first read word is marked valid exactly the programmed latency after the command edge.

Bursts can be cut short in two ways: by a new read or write command, or by a stop command. A full-page burst runs over the whole column space and keeps wrapping until one of those arrives.

Top module: `bseq_top`

## Requirements
- R1: After reset, colActive, burstDone and rdValid are low. The mode register then selects one-beat bursts, sequential order, latency 2 and single-beat writes off.
- R2: A mode-set command (cmdOp=1) loads the mode from cmdKey. Bits [2:0] give the length: 0, 1, 2 and 3 select 1, 2, 4 and 8 beats, 7 selects full page, and 4 to 6 select one beat. Bit [3] selects interleaved order. Bits [6:4] equal to 3 select latency 3. Bit [9] enables single-beat writes.
- R3: In sequential order, beat k of a burst of length L starting at column S presents column (S with its low log2(L) bits replaced by (S+k) mod L).
- R4: In interleaved order, beat k presents column S XOR k. A full-page burst always uses sequential order.
- R5: A full-page burst presents (S+k) mod 256 and keeps going past 256 beats until a stop or a new command.
- R6: rdValid is high exactly CL cycles after each command edge that issued a read beat. Here the read command edge is cycle 0, beat k is cycle k, and CL is the current latency (2 or 3). Latency key values other than 3 give 2.
- R7: With single-beat writes on, a write (cmdOp=3) transfers one beat, while a read (cmdOp=2) keeps the programmed length.
- R8: During a burst, colBank equals the cmdBank of its command, and colIsWrite is high for a write.
- R9: A read or write command accepted during a burst ends that burst. The new burst's first beat appears on the next cycle.
- R10: A stop command (cmdOp=4) ends the burst, so colActive is low on the next cycle. Read beats that were already issued still produce their rdValid pulses.
- R11: burstDone is high only during the last beat of a fixed-length burst, and never during a full-page burst. colActive falls on the cycle after it unless a new command arrives.
- R12: A mode-set command during a burst does not change that burst's length, order or addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdOp | input | 3 | 0 idle, 1 mode set, 2 read, 3 write, 4 stop |
| cmdBank | input | 1 | Bank select of a read or write |
| cmdKey | input | 10 | Mode key, or start column in the low COL_W bits |
| colAddr | output | COL_W | Column of the current beat |
| colBank | output | 1 | Bank of the current beat |
| colActive | output | 1 | A beat is presented this cycle |
| colIsWrite | output | 1 | The current burst is a write |
| burstDone | output | 1 | The current beat is the last |
| rdValid | output | 1 | Read data valid, delayed by the latency |

## Verification
The hardest case to reach is the wrap of a full-page burst past column 255 while interleaved order is selected. It is made harder when a latency-3 read pipeline is still draining as a stop or a new command cuts the burst. The stimulus sweeps every length code, both orders, both latencies, both write modes and several start columns, including ones near the top of the column space. Full-page bursts run for more than 256 beats before a stop. Directed sequences then insert a new command, a stop and a mode set in the middle of a burst.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int KEY_W = 10;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_MODE  = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_STOP  = 3'd4
  } cmdOp_e;

  typedef struct packed {
    logic       load;
    logic       step;
    logic       readBeat;
    logic       interleave;
    logic       fullPage;
    logic [2:0] lenLog;
    logic       cl3;
  } ctrlStrobes_t;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         cmdOp,
  input  logic [KEY_W-1:0]   modeKey,
  output ctrlStrobes_t       strb,
  output logic               beatActive,
  output logic               beatIsWrite,
  output logic               lastBeat
);

  localparam logic [2:0] LEN_FULL = 3'd7;
  localparam logic [2:0] LAT_3    = 3'd3;

  logic [2:0]       modeLenCode;
  logic             modeInter;
  logic             modeCl3;
  logic             modeSingle;

  logic             active;
  logic             isWrite;
  logic             fullPage;
  logic [COL_W-1:0] beatsLeft;

  logic             isRw;
  logic             newWrite;
  logic             newSingle;
  logic             newFull;
  logic [2:0]       newLog;
  logic [COL_W-1:0] newLeft;
  logic             unusedKeyBits;

  assign unusedKeyBits = ^modeKey[8:7];

  always_comb begin
    isRw      = (cmdOp == OP_READ) || (cmdOp == OP_WRITE);
    newWrite  = (cmdOp == OP_WRITE);
    newSingle = newWrite && modeSingle;
    newFull   = !newSingle && (modeLenCode == LEN_FULL);
    if (newSingle || modeLenCode > 3'd3) newLog = 3'd0;
    else                                 newLog = modeLenCode;
    if (newFull) newLeft = '0;
    else         newLeft = ~({COL_W{1'b1}} << newLog);
    lastBeat  = active && !fullPage && (beatsLeft == '0);
  end

  always_comb begin
    strb.load       = isRw;
    strb.step       = !isRw && (cmdOp != OP_STOP) && active && !lastBeat;
    strb.readBeat   = active && !isWrite;
    strb.interleave = modeInter && !newFull;
    strb.fullPage   = newFull;
    strb.lenLog     = newLog;
    strb.cl3        = modeCl3;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeLenCode <= 3'd0;
      modeInter   <= 1'b0;
      modeCl3     <= 1'b0;
      modeSingle  <= 1'b0;
    end else if (cmdOp == OP_MODE) begin
      modeLenCode <= modeKey[2:0];
      modeInter   <= modeKey[3];
      modeCl3     <= (modeKey[6:4] == LAT_3);
      modeSingle  <= modeKey[9];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      isWrite   <= 1'b0;
      fullPage  <= 1'b0;
      beatsLeft <= '0;
    end else if (isRw) begin
      active    <= 1'b1;
      isWrite   <= newWrite;
      fullPage  <= newFull;
      beatsLeft <= newLeft;
    end else if (cmdOp == OP_STOP) begin
      active    <= 1'b0;
    end else if (active) begin
      if (lastBeat)       active    <= 1'b0;
      else if (!fullPage) beatsLeft <= beatsLeft - 1'b1;
    end
  end

  assign beatActive  = active;
  assign beatIsWrite = isWrite;

endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int MAX_LAT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic             cmdBank,
  input  logic [COL_W-1:0] startIn,
  output logic [COL_W-1:0] colAddr,
  output logic             colBank,
  output logic             rdValid
);

  localparam int PIPE_D = MAX_LAT - 1;

  logic [COL_W-1:0]  startCol;
  logic [COL_W-1:0]  offset;
  logic [COL_W-1:0]  mask;
  logic              inter;
  logic              bank;
  logic [PIPE_D-1:0] rdPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startCol <= '0;
      offset   <= '0;
      mask     <= '0;
      inter    <= 1'b0;
      bank     <= 1'b0;
    end else if (strb.load) begin
      startCol <= startIn;
      offset   <= '0;
      mask     <= strb.fullPage ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << strb.lenLog);
      inter    <= strb.interleave;
      bank     <= cmdBank;
    end else if (strb.step) begin
      offset   <= offset + 1'b1;
    end
  end

  always_comb begin
    if (inter) colAddr = startCol ^ offset;
    else       colAddr = (startCol & ~mask) | ((startCol + offset) & mask);
  end

  generate
    for (genvar i = 0; i < PIPE_D; i++) begin : g_rdPipe
      always_ff @(posedge clk) begin
        if (!rstN)       rdPipe[i] <= 1'b0;
        else if (i == 0) rdPipe[i] <= strb.readBeat;
        else             rdPipe[i] <= rdPipe[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  assign rdValid = strb.cl3 ? rdPipe[PIPE_D-1] : rdPipe[0];
  assign colBank = bank;

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmdOp,
  input  logic             cmdBank,
  input  logic [9:0]       cmdKey,
  output logic [COL_W-1:0] colAddr,
  output logic             colBank,
  output logic             colActive,
  output logic             colIsWrite,
  output logic             burstDone,
  output logic             rdValid
);

  ctrlStrobes_t strb;

  bseq_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdOp      (cmdOp),
    .modeKey    (cmdKey),
    .strb       (strb),
    .beatActive (colActive),
    .beatIsWrite(colIsWrite),
    .lastBeat   (burstDone)
  );

  bseq_datapath #(.COL_W(COL_W), .MAX_LAT(3)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdBank (cmdBank),
    .startIn (cmdKey[COL_W-1:0]),
    .colAddr (colAddr),
    .colBank (colBank),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cmdOp,
  input logic             cmdBank,
  input logic [9:0]       cmdKey,
  input logic [COL_W-1:0] colAddr,
  input logic             colBank,
  input logic             colActive,
  input logic             colIsWrite,
  input logic             burstDone,
  input logic             rdValid
);

  logic isRw;
  assign isRw = (cmdOp == 3'd2) || (cmdOp == 3'd3);

  // R9: a command presents its start column and bank on the next cycle
  a_r9_first_beat: assert property (@(posedge clk) disable iff (!rstN)
    isRw |=> colActive && colAddr == $past(cmdKey[COL_W-1:0]) && colBank == $past(cmdBank));

  // R8: write flag follows the command
  a_r8_write_flag: assert property (@(posedge clk) disable iff (!rstN)
    isRw |=> colIsWrite == $past(cmdOp == 3'd3));

  // R10: stop ends the burst
  a_r10_stop: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp == 3'd4 |=> !colActive);

  // R11: done only on an active beat, and the burst ends after it
  a_r11_done_active: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> colActive);

  a_r11_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    burstDone && !isRw |=> !colActive);

  // R3: a burst that is not at its end continues
  a_r3_continues: assert property (@(posedge clk) disable iff (!rstN)
    colActive && !burstDone && (cmdOp == 3'd0 || cmdOp == 3'd1) |=> colActive && colBank == $past(colBank));

  // R6: read-valid only follows an issued read beat
  a_r6_rd_source: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(colActive && !colIsWrite) || $past(colActive && !colIsWrite, 2));

endmodule

bind bseq_top bseq_checker #(.COL_W(COL_W)) i_bseq_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cmdOp     (cmdOp),
  .cmdBank   (cmdBank),
  .cmdKey    (cmdKey),
  .colAddr   (colAddr),
  .colBank   (colBank),
  .colActive (colActive),
  .colIsWrite(colIsWrite),
  .burstDone (burstDone),
  .rdValid   (rdValid)
);

// File: tb/test_bseq_top.sv
module test_bseq_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic       cmdBank = 1'b0;
  logic [9:0] cmdKey = '0;
  logic [7:0] colAddr;
  logic       colBank, colActive, colIsWrite, burstDone, rdValid;

  bseq_top #(.COL_W(8)) i_bseq_top (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdKey(cmdKey),
    .colAddr(colAddr), .colBank(colBank), .colActive(colActive),
    .colIsWrite(colIsWrite), .burstDone(burstDone), .rdValid(rdValid)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curTag = "R1";

  // reference model state
  int mLen = 0, mInter = 0, mCl = 2, mSingle = 0;
  int eActive = 0, eWr = 0, eBank = 0, eStart = 0, eBeat = 0, eLen = 1, eInter = 0, eFull = 0;
  int h0 = 0, h1 = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int expAddr(int s, int k, int len, int inter, int full);
    if (full != 0)  return (s + k) % 256;
    if (inter != 0) return s ^ k;
    return s - (s % len) + ((s % len) + k) % len;
  endfunction

  task automatic step(input int op, input int bank, input int key);
    int eDone, eRd;
    @(negedge clk);
    eDone = (eActive != 0 && eFull == 0 && eBeat == eLen - 1) ? 1 : 0;
    eRd   = (mCl == 3) ? h1 : h0;
    chk(curTag, "colActive", colActive, eActive);
    chk("R11", "burstDone", burstDone, eDone);
    chk("R6", "rdValid", rdValid, eRd);
    if (eActive != 0) begin
      chk(curTag, "colAddr", colAddr, expAddr(eStart, eBeat, eLen, eInter, eFull));
      chk("R8", "colBank", colBank, eBank);
      chk("R8", "colIsWrite", colIsWrite, eWr);
    end
    h1 = h0;
    h0 = (eActive != 0 && eWr == 0) ? 1 : 0;
    cmdOp   = 3'(op);
    cmdBank = 1'(bank);
    cmdKey  = 10'(key);
    // model update for the coming edge
    if (op == 2 || op == 3) begin
      int single;
      single  = (op == 3 && mSingle != 0) ? 1 : 0;
      eActive = 1;
      eWr     = (op == 3) ? 1 : 0;
      eBank   = bank;
      eStart  = key % 256;
      eFull   = (single == 0 && mLen == 7) ? 1 : 0;
      if (eFull != 0)                    eLen = 256;
      else if (single != 0 || mLen > 3)  eLen = 1;
      else                               eLen = 1 << mLen;
      eInter  = (mInter != 0 && eFull == 0) ? 1 : 0;
      eBeat   = 0;
    end else if (op == 4) begin
      eActive = 0;
    end else if (eActive != 0) begin
      if (eFull == 0 && eBeat == eLen - 1) eActive = 0;
      else eBeat = (eBeat + 1) % 256;
    end
    if (op == 1) begin
      mLen    = key % 8;
      mInter  = (key >> 3) % 2;
      mCl     = (((key >> 4) % 8) == 3) ? 3 : 2;
      mSingle = (key >> 9) % 2;
    end
  endtask

  function automatic int modeKeyOf(int len, int inter, int cl, int single);
    return (single << 9) | (cl << 4) | (inter << 3) | len;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    int starts[4];
    starts = '{8'h00, 8'h05, 8'h3e, 8'hfb};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state and default mode
    @(negedge clk);
    chk("R1", "colActive after reset", colActive, 0);
    chk("R1", "burstDone after reset", burstDone, 0);
    chk("R1", "rdValid after reset", rdValid, 0);
    curTag = "R1";
    step(2, 1, 8'h47);
    idle(5);

    for (int cl = 2; cl <= 3; cl++)
      for (int len = 0; len < 8; len++)
        for (int inter = 0; inter < 2; inter++)
          for (int single = 0; single < 2; single++)
            for (int wr = 0; wr < 2; wr++)
              for (int si = 0; si < 4; si++) begin
                curTag = "R2";
                step(1, 0, modeKeyOf(len, inter, cl, single));
                idle(1);
                if (single != 0 && wr != 0)  curTag = "R7";
                else if (len == 7)           curTag = "R5";
                else if (len > 3)            curTag = "R2";
                else if (inter != 0)         curTag = "R4";
                else                         curTag = "R3";
                step(2 + wr, si % 2, starts[si]);
                if (eFull != 0) begin
                  idle(260);
                  step(4, 0, 0);
                end
                idle(10);
              end

    // R6: latency key other than 3 selects 2
    curTag = "R6";
    step(1, 0, modeKeyOf(2, 0, 5, 0));
    step(2, 0, 8'h10);
    idle(8);

    // R9: new command truncates a read, then back-to-back commands
    curTag = "R9";
    step(1, 0, modeKeyOf(3, 0, 3, 0));
    step(2, 0, 8'h13);
    idle(3);
    step(3, 1, 8'h20);
    idle(2);
    step(2, 0, 8'h77);
    step(2, 1, 8'h81);
    idle(12);

    // R10: stop in the middle of a latency-3 read
    curTag = "R10";
    step(2, 0, 8'hf9);
    idle(2);
    step(4, 0, 0);
    idle(6);

    // R12: mode set during a burst leaves it alone
    curTag = "R12";
    step(1, 0, modeKeyOf(3, 1, 2, 0));
    step(2, 1, 8'h2d);
    idle(2);
    step(1, 0, modeKeyOf(0, 0, 3, 1));
    idle(10);
    step(3, 0, 8'h44);
    idle(6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule